// File: doc/BRIEF.md
# Two-Tap Line Reassembler

This block rebuilds one image line from a sensor whose horizontal shift register is split in the middle and read out from both ends at once. The left tap delivers its half in natural left-to-right order. The right tap delivers its half mirrored, starting at the right edge of the array. Each tap has its own pixel-valid strobe and start-of-line marker. Every clocked line on a tap begins with a few empty pixels and then a run of light-shielded pixels before the photosensitive run. The counts differ between the taps.

In two-tap mode the block discards each tap's prefix. It stores the photosensitive pixels of both halves in two line buffers, with the right half written at mirrored addresses. Once both halves are complete, it replays the joined line as one contiguous stream with start-of-line and end-of-line flags. In single-tap mode the whole line arrives on the left tap. The block forwards the photosensitive run directly and trims the empty pixels and the shielded pixels at both ends. An overrun pulse reports a new line that starts while a replay is still running.

Top module: `line_reassembler`

## Requirements
- R1: While `rst_n` is low and after it is released, `o_vld`, `o_sol`, `o_eol` and `overrun` are 0 until line data causes output.
- R2: In two-tap mode (`dual`=1), each output line holds `L_ACT` + `R_ACT` pixels: the left photosensitive pixels in arrival order, followed by the right photosensitive pixels in the reverse of their arrival order. This gives a spatially ordered line.
- R3: Pixel index counts valid pixels from 0 at the pixel that carries start-of-line. On the left tap, indices below `EMPTY`+`L_DARK` never reach the output. On the right tap, indices below `EMPTY`+`R_DARK` never reach the output.
- R4: `o_sol` is high only on the first pixel of an output line and `o_eol` only on its last. Both are high only together with `o_vld`.
- R5: In two-tap mode, the first output pixel is valid two clock edges after the edge that captures the later of the two taps' final photosensitive pixels. The remaining pixels follow on consecutive cycles.
- R6: The two taps may start at different times and may contain gaps in pixel-valid. The reassembled line does not depend on the skew or on the gaps.
- R7: In single-tap mode (`dual`=0), left-tap pixels with index `EMPTY`+`S_DARK` through `EMPTY`+`S_DARK`+`S_ACT`-1 are output one cycle after they arrive, flagged first and last. All other left-tap pixels are dropped, and the right tap is ignored.
- R8: `overrun` pulses for one cycle, one edge after either tap presents a valid start-of-line in two-tap mode while a replay is in progress. It is low otherwise.
- R9: A valid start-of-line restarts that tap's pixel count, so a partial line followed by a full line produces only the full line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual | input | 1 | 1 = two-tap reassembly, 0 = single-tap pass-through |
| l_vld | input | 1 | Left tap pixel valid |
| l_sol | input | 1 | Left tap start of line, qualified by `l_vld` |
| l_pix | input | DW | Left tap pixel value |
| r_vld | input | 1 | Right tap pixel valid |
| r_sol | input | 1 | Right tap start of line, qualified by `r_vld` |
| r_pix | input | DW | Right tap pixel value |
| o_vld | output | 1 | Output pixel valid |
| o_sol | output | 1 | First pixel of output line |
| o_eol | output | 1 | Last pixel of output line |
| o_pix | output | DW | Output pixel value |
| overrun | output | 1 | One-cycle pulse: line start during replay |

## Verification
Both taps carry a spatial ramp, with the right tap sent mirrored and the prefix pixels filled with large out-of-ramp values. Any ordering mistake, missed reversal or leaked prefix pixel therefore breaks the strict +1 progression of the output. The patterns are:
- aligned taps, which test the basic join;
- the right tap delayed, and the left tap delayed with valid gaps on both taps, which separate skew handling from counting;
- a truncated line followed by a full one, which shows that start-of-line resynchronises the count;
- a lone start-of-line during a replay, which must raise overrun without disturbing the line being replayed;
- single-tap lines, with garbage driven on the right tap, which show the pass-through trimming and that the right input is ignored.

// File: rtl/line_reassembler.sv
module line_reassembler #(
  parameter int DW     = 12,
  parameter int EMPTY  = 4,
  parameter int L_DARK = 20,
  parameter int L_ACT  = 2016,
  parameter int R_DARK = 19,
  parameter int R_ACT  = 2017,
  parameter int S_DARK = 20,
  parameter int S_ACT  = 4032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic          l_vld,
  input  logic          l_sol,
  input  logic [DW-1:0] l_pix,
  input  logic          r_vld,
  input  logic          r_sol,
  input  logic [DW-1:0] r_pix,
  output logic          o_vld,
  output logic          o_sol,
  output logic          o_eol,
  output logic [DW-1:0] o_pix,
  output logic          overrun
);

  localparam int LINE = L_ACT + R_ACT;
  localparam int LAW  = $clog2(L_ACT);
  localparam int RAW  = $clog2(R_ACT);
  localparam int AW   = $clog2(LINE);
  localparam int CW   = $clog2(EMPTY + L_DARK + R_DARK + 2*S_DARK + S_ACT + LINE + 1);

  localparam logic [CW-1:0] L_LO = CW'(EMPTY + L_DARK);
  localparam logic [CW-1:0] L_HI = CW'(EMPTY + L_DARK + L_ACT - 1);
  localparam logic [CW-1:0] R_LO = CW'(EMPTY + R_DARK);
  localparam logic [CW-1:0] R_HI = CW'(EMPTY + R_DARK + R_ACT - 1);
  localparam logic [CW-1:0] S_LO = CW'(EMPTY + S_DARK);
  localparam logic [CW-1:0] S_HI = CW'(EMPTY + S_DARK + S_ACT - 1);
  localparam logic [AW-1:0] SPLIT = AW'(L_ACT);
  localparam logic [AW-1:0] LAST  = AW'(LINE - 1);

  logic [DW-1:0] lbuf [L_ACT];
  logic [DW-1:0] rbuf [R_ACT];
  logic [CW-1:0] l_cnt, r_cnt;
  logic          l_done, r_done, busy;
  logic [AW-1:0] rd_ptr;

  wire [CW-1:0] l_idx = l_sol ? '0 : l_cnt;
  wire [CW-1:0] r_idx = r_sol ? '0 : r_cnt;

  wire l_wr   = dual && l_vld && (l_idx >= L_LO) && (l_idx <= L_HI);
  wire r_wr   = dual && r_vld && (r_idx >= R_LO) && (r_idx <= R_HI);
  wire s_pass = !dual && l_vld && (l_idx >= S_LO) && (l_idx <= S_HI);
  wire start  = l_done && r_done && !busy;
  wire new_ln = (l_vld && l_sol) || (r_vld && r_sol);

  wire [DW-1:0] rd_data = (rd_ptr < SPLIT) ? lbuf[LAW'(rd_ptr)]
                                           : rbuf[RAW'(rd_ptr - SPLIT)];

  always_ff @(posedge clk) begin
    if (l_wr) lbuf[LAW'(l_idx - L_LO)] <= l_pix;
    if (r_wr) rbuf[RAW'(R_HI - r_idx)] <= r_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_cnt <= '0;
      r_cnt <= '0;
    end else begin
      if (l_vld) l_cnt <= l_idx + CW'(1);
      if (r_vld) r_cnt <= r_idx + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_done <= 1'b0;
      r_done <= 1'b0;
      busy   <= 1'b0;
      rd_ptr <= '0;
    end else begin
      l_done <= (l_done && !start) || (l_wr && l_idx == L_HI);
      r_done <= (r_done && !start) || (r_wr && r_idx == R_HI);
      if (start) begin
        busy   <= 1'b1;
        rd_ptr <= '0;
      end else if (busy) begin
        if (rd_ptr == LAST) busy <= 1'b0;
        rd_ptr <= rd_ptr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld   <= 1'b0;
      o_sol   <= 1'b0;
      o_eol   <= 1'b0;
      o_pix   <= '0;
      overrun <= 1'b0;
    end else begin
      o_vld   <= 1'b0;
      o_sol   <= 1'b0;
      o_eol   <= 1'b0;
      overrun <= dual && busy && new_ln;
      if (busy) begin
        o_vld <= 1'b1;
        o_pix <= rd_data;
        o_sol <= (rd_ptr == '0);
        o_eol <= (rd_ptr == LAST);
      end else if (s_pass) begin
        o_vld <= 1'b1;
        o_pix <= l_pix;
        o_sol <= (l_idx == S_LO);
        o_eol <= (l_idx == S_HI);
      end
    end
  end

endmodule

// File: rtl/line_reassembler_chk.sv
module line_reassembler_chk (
  input logic clk,
  input logic rst_n,
  input logic dual,
  input logic l_vld,
  input logic l_sol,
  input logic r_vld,
  input logic r_sol,
  input logic o_vld,
  input logic o_sol,
  input logic o_eol,
  input logic overrun
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!o_vld && !overrun));

  // R4
  flags_need_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_sol || o_eol) |-> o_vld);

  // R5
  replay_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && o_vld && !o_eol) |=> (o_vld || !dual));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(dual && ((l_vld && l_sol) || (r_vld && r_sol))));

  // R7
  single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && $past(!dual) && o_vld) |-> $past(l_vld));

endmodule

bind line_reassembler line_reassembler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dual(dual),
  .l_vld(l_vld), .l_sol(l_sol), .r_vld(r_vld), .r_sol(r_sol),
  .o_vld(o_vld), .o_sol(o_sol), .o_eol(o_eol), .overrun(overrun)
);

// File: tb/line_reassembler_tb.sv
module line_reassembler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, EMPTY = 4, L_DARK = 20, L_ACT = 16, R_DARK = 19, R_ACT = 17;
  localparam int S_DARK = 20, S_ACT = 32;
  localparam int LINE = L_ACT + R_ACT;
  localparam int LLO = EMPTY + L_DARK, LHI = LLO + L_ACT - 1;
  localparam int RLO = EMPTY + R_DARK, RHI = RLO + R_ACT - 1;
  localparam int SLO = EMPTY + S_DARK, SHI = SLO + S_ACT - 1;
  localparam int LTOT = LHI + 1, RTOT = RHI + 1, STOT = SHI + 1 + S_DARK;

  logic clk = 0, rst_n = 0, dual = 0;
  logic l_vld = 0, l_sol = 0, r_vld = 0, r_sol = 0;
  logic [DW-1:0] l_pix = '0, r_pix = '0;
  logic o_vld, o_sol, o_eol, overrun;
  logic [DW-1:0] o_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_reassembler #(.DW(DW), .EMPTY(EMPTY), .L_DARK(L_DARK), .L_ACT(L_ACT),
    .R_DARK(R_DARK), .R_ACT(R_ACT), .S_DARK(S_DARK), .S_ACT(S_ACT)) u_dut (
    .clk(clk), .rst_n(rst_n), .dual(dual),
    .l_vld(l_vld), .l_sol(l_sol), .l_pix(l_pix),
    .r_vld(r_vld), .r_sol(r_sol), .r_pix(r_pix),
    .o_vld(o_vld), .o_sol(o_sol), .o_eol(o_eol), .o_pix(o_pix), .overrun(overrun));

  int checks = 0, failures = 0, lines_out = 0, ovr_seen = 0, wd = 0;
  string phase = "R2";
  bit done_run = 0;

  // reference model state
  int lq[$], rq[$], oq[$];
  int lcnt, rcnt, cyc, go_at, eidx, prev_pix;
  bit ldn, rdn, e_vld, e_sol, e_eol, e_ovr;
  int e_pix;

  task automatic finish_run;
    if (!done_run) begin
      done_run = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lq.delete(); rq.delete(); oq.delete();
      lcnt = 0; rcnt = 0; cyc = 0; go_at = 0; eidx = 0;
      ldn = 0; rdn = 0; e_vld = 0; e_sol = 0; e_eol = 0; e_ovr = 0; e_pix = 0;
    end else begin
      bit emitting;
      cyc++;
      e_vld = 0; e_sol = 0; e_eol = 0; e_ovr = 0;
      emitting = (oq.size() > 0) && (cyc >= go_at);
      if (dual && ((l_vld && l_sol) || (r_vld && r_sol)) && emitting) e_ovr = 1;
      if (emitting) begin
        e_pix = oq.pop_front(); e_vld = 1; e_sol = (eidx == 0); eidx++;
        e_eol = (oq.size() == 0);
        if (e_eol) eidx = 0;
      end
      if (l_vld) begin
        int k;
        k = l_sol ? 0 : lcnt; lcnt = k + 1;
        if (dual) begin
          if (k == 0) lq.delete();
          if (k >= LLO && k <= LHI) lq.push_back(int'(l_pix));
          if (k == LHI) ldn = 1;
        end else if (k >= SLO && k <= SHI) begin
          e_vld = 1; e_pix = int'(l_pix); e_sol = (k == SLO); e_eol = (k == SHI);
        end
      end
      if (r_vld) begin
        int k;
        k = r_sol ? 0 : rcnt; rcnt = k + 1;
        if (dual) begin
          if (k == 0) rq.delete();
          if (k >= RLO && k <= RHI) rq.push_back(int'(r_pix));
          if (k == RHI) rdn = 1;
        end
      end
      if (ldn && rdn && oq.size() == 0) begin
        foreach (lq[j]) oq.push_back(lq[j]);
        for (int j = rq.size() - 1; j >= 0; j--) oq.push_back(rq[j]);
        go_at = cyc + 2; ldn = 0; rdn = 0; lq.delete(); rq.delete();
      end
    end
  end

  always @(negedge clk) begin
    if (!done_run) begin
      chk(o_vld === e_vld, dual ? "R5 o_vld" : "R7 o_vld", o_vld, e_vld);
      if (e_vld && o_vld) begin
        chk(o_pix === DW'(e_pix), {phase, " o_pix"}, o_pix, e_pix);
        chk(o_sol === e_sol && o_eol === e_eol, "R4 flags", {o_sol, o_eol}, {e_sol, e_eol});
        // R3: prefix fill values (>= 'hC00) must never appear
        chk(o_pix < 12'hC00, "R3 prefix leak", o_pix, 0);
        if (!o_sol) chk(int'(o_pix) == prev_pix + 1, "R2 monotonic", o_pix, prev_pix + 1);
        prev_pix = int'(o_pix);
        if (o_eol) lines_out++;
      end
      chk(overrun === e_ovr, "R8 overrun", overrun, e_ovr);
      if (overrun) ovr_seen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL R5 watchdog expired");
      finish_run();
    end
  end

  function automatic logic [DW-1:0] lval(input int i, input int base);
    if (dual) return (i >= LLO && i <= LHI) ? DW'(base + i - LLO) : DW'(12'hF00 + i);
    return (i >= SLO && i <= SHI) ? DW'(base + i - SLO) : DW'(12'hF00 + (i % 64));
  endfunction

  function automatic logic [DW-1:0] rval(input int i, input int base);
    return (i >= RLO && i <= RHI) ? DW'(base + L_ACT + (RHI - i)) : DW'(12'hE00 + i);
  endfunction

  task automatic drive(input int base, input int lskew, input int rskew, input int gap,
                       input int nl, input int nr);
    int li = 0, ri = 0, lw = lskew, rw = rskew, t = 0;
    while (li < nl || ri < nr) begin
      @(negedge clk);
      l_vld = 0; l_sol = 0; r_vld = 0; r_sol = 0;
      if (lw > 0) lw--;
      else if (li < nl && !(gap > 0 && (t % gap) == gap - 1)) begin
        l_vld = 1; l_sol = (li == 0); l_pix = lval(li, base); li++;
      end
      if (rw > 0) rw--;
      else if (ri < nr && !(gap > 0 && (t % gap) == 0)) begin
        r_vld = 1; r_sol = (ri == 0); r_pix = rval(ri, base); ri++;
      end
      t++;
    end
    @(negedge clk);
    l_vld = 0; l_sol = 0; r_vld = 0; r_sol = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(o_vld == 0 && overrun == 0 && o_sol == 0 && o_eol == 0, "R1 in reset", o_vld, 0);
    rst_n = 1;
    idle(3);
    chk(o_vld == 0 && overrun == 0, "R1 after release", o_vld, 0);
    dual = 1;

    phase = "R2"; drive(100, 0, 0, 0, LTOT, RTOT); idle(LINE + 8);
    phase = "R6"; drive(200, 0, 11, 0, LTOT, RTOT); idle(LINE + 8);
    phase = "R6"; drive(300, 9, 0, 3, LTOT, RTOT); idle(LINE + 8);
    phase = "R9"; drive(12'h900, 0, 0, 0, 30, 30); idle(4);
    drive(400, 0, 0, 0, LTOT, RTOT); idle(LINE + 8);
    phase = "R8"; drive(500, 0, 0, 0, LTOT, RTOT); idle(3);
    drive(0, 0, 0, 0, 0, 3); idle(LINE + 8);
    chk(ovr_seen == 1, "R8 overrun count", ovr_seen, 1);
    phase = "R9"; drive(600, 2, 0, 0, LTOT, RTOT); idle(LINE + 8);

    dual = 0; idle(2);
    phase = "R7"; drive(700, 0, 0, 0, STOT, STOT); idle(6);
    drive(800, 0, 5, 4, STOT, STOT); idle(6);

    // R4: one end-of-line per reassembled or passed line
    chk(lines_out == 8, "R4 line count", lines_out, 8);
    chk(ovr_seen == 1, "R8 no spurious overrun", ovr_seen, 1);
    finish_run();
  end
endmodule